// File: doc/BRIEF.md
# Device-to-Host Stream Write Agent

This block takes a byte stream from user logic on an AXI-Stream sink and turns it into write-request packets bound for host memory. Software-visible control is not part of the block: a descriptor (destination byte address and byte length) arrives on a valid/ready port, and the agent answers with one command packet on an AXI-Stream master toward the arbiter. Each packet is a header beat carrying the address and length, followed by the payload beats. When the packet is done, the agent pulses a completion that reports how many bytes were actually moved.

Incoming beats are narrower than the internal word. A packer folds several input beats into one internal word and trims the last beat of a descriptor to the byte budget. A small FIFO of packed words separates the sink from the master port. Destination addresses and lengths may be any byte value when `UNALIGNED_EN` is set; when it is clear, the address is rounded down to an internal-word boundary.

A soft reset request drains the sink and the FIFO, discarding everything, then clears the agent's registers and raises a done flag.

The control state machine has six states:
- `ST_IDLE`: waits for a descriptor.
- `ST_HDR`: presents the header beat.
- `ST_PAY`: forwards packed words.
- `ST_CPL`: issues the completion pulse.
- `ST_DRAIN`: swallows input and empties the FIFO.
- `ST_CLEAR`: clears state.

Transitions:
- Accepting a descriptor moves `ST_IDLE` to `ST_HDR`.
- A header handshake moves `ST_HDR` to `ST_PAY`.
- A handshake on the last payload word moves `ST_PAY` to `ST_CPL`.
- `ST_CPL` returns to `ST_IDLE`.
- A soft reset request moves any state except `ST_DRAIN` to `ST_DRAIN`.
- An idle sink together with an empty FIFO moves `ST_DRAIN` to `ST_CLEAR`.
- `ST_CLEAR` returns to `ST_IDLE`.

Top module: `d2h_stream_agent`

## Requirements
- R1: After reset, `s_tready`, `m_tvalid`, `cpl_valid` and `srst_done` are 0 and `desc_ready` is 1.
- R2: The first beat after a descriptor is accepted is the header. It carries the address in `m_tdata[ADDR_W-1:0]` and the length in `m_tdata[ADDR_W +: LEN_W]`, with all other data bits 0, `m_tkeep` all ones and `m_tlast` 0.
- R3: Input beat k of a descriptor (counting from 0) is placed in payload word k/RATIO, at lane k mod RATIO, where lane 0 is the least significant IN_W bits.
- R4: Each payload word has `m_tkeep` equal to its low n bits set, where n is the number of valid bytes in that word. Only the final payload word may be partial, and only that word has `m_tlast` set.
- R5: A descriptor consumes exactly its length in bytes, for any byte length and address. A beat that crosses the end contributes only the remaining bytes, and `s_tready` stays low after that beat until a new descriptor is active.
- R6: A `s_tlast` that arrives before the length is used up ends the descriptor. The completion then reports the bytes actually received, with `cpl_early` = 1.
- R7: Exactly one single-cycle `cpl_valid` follows each packet, in the cycle after the handshake of the last payload word. A descriptor that runs to its full length reports `cpl_bytes` equal to its length, with `cpl_early` = 0.
- R8: `s_tready` is low whenever no descriptor is active or the FIFO is full.
- R9: While `m_tvalid` is high and `m_tready` is low, the beat (data, keep, last) holds unchanged in the next cycle.
- R10: A `srst_req` pulse discards buffered and arriving data. While draining, `s_tready` is 1 and `m_tvalid` and `cpl_valid` are 0. `srst_done` goes to 1 once the sink is idle and the FIFO is empty, and it is cleared by the next request. No stale data appears in later packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | IN_W | Sink stream data from user logic |
| s_tvalid | input | 1 | Sink beat valid |
| s_tready | output | 1 | Sink beat accepted |
| s_tlast | input | 1 | Sink end of user packet |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted |
| desc_addr | input | ADDR_W | Destination byte address |
| desc_len | input | LEN_W | Byte length (1 or more) |
| m_tdata | output | DATA_W | Command packet data toward arbiter |
| m_tkeep | output | DATA_W/8 | Byte enables of the command beat |
| m_tvalid | output | 1 | Command beat valid |
| m_tready | input | 1 | Arbiter accepts the beat |
| m_tlast | output | 1 | Final beat of the command packet |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_bytes | output | LEN_W | Bytes moved for the finished descriptor |
| cpl_early | output | 1 | Descriptor ended by an early tlast |
| srst_req | input | 1 | Soft reset request pulse |
| srst_done | output | 1 | Soft reset sequence finished |

## Verification
Some properties are checked on every clock:
- the beat holds stable under backpressure;
- byte enables are contiguous from the low end;
- the completion is a single pulse that follows a last-beat handshake;
- the reported byte count is consistent with the early flag;
- the sink is not ready while a descriptor can still be accepted;
- the drain state stays quiet.

Other behaviour only shows up in the bench scenarios, where a scoreboard compares every packet beat and completion against values computed from the descriptor and the beats sent. These scenarios cover lane placement across beats, trimming at odd lengths and addresses, early termination, the FIFO-full stall of the sink, and the absence of stale words after a soft reset.

// File: rtl/d2h_agent_pkg.sv
package d2h_agent_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_CPL,
        ST_DRAIN,
        ST_CLEAR
    } agent_state_e;

endpackage

// File: rtl/d2h_fifo.sv
module d2h_fifo #(
    parameter int W     = 74,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W:0] wr_q, rd_q;

    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[PTR_W] != rd_q[PTR_W]) &&
                   (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
    assign rdata = mem[rd_q[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_q[PTR_W-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else if (clear) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push && !full) wr_q <= wr_q + 1'b1;
            if (pop && !empty) rd_q <= rd_q + 1'b1;
        end
    end
endmodule

// File: rtl/d2h_pack.sv
module d2h_pack #(
    parameter int IN_W   = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              in_en,
    input  logic              fifo_full,
    input  logic              s_tvalid,
    input  logic [IN_W-1:0]   s_tdata,
    input  logic              s_tlast,
    output logic              ready,
    output logic              push,
    output logic [DATA_W-1:0] push_word,
    output logic [CNT_W-1:0]  push_bytes,
    output logic              push_last,
    output logic [LEN_W-1:0]  total,
    output logic              early
);
    localparam int IN_BYTES = IN_W / 8;
    localparam int RATIO    = DATA_W / IN_W;
    localparam int IDX_W    = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [LEN_W-1:0]  rem_q, total_q, taken;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [CNT_W-1:0]  wbytes_q;
    logic              done_q, early_q;
    logic              accept, fin, lane_full;

    assign ready     = in_en && !done_q && !fifo_full;
    assign accept    = ready && s_tvalid;
    assign taken     = (rem_q < LEN_W'(IN_BYTES)) ? rem_q : LEN_W'(IN_BYTES);
    assign fin       = s_tlast || (rem_q <= LEN_W'(IN_BYTES));
    assign lane_full = (idx_q == IDX_W'(RATIO - 1));

    always_comb begin
        push_word = wbuf_q;
        for (int l = 0; l < RATIO; l++) begin
            if (idx_q == IDX_W'(l)) push_word[l*IN_W +: IN_W] = s_tdata;
        end
    end

    assign push       = accept && (fin || lane_full);
    assign push_bytes = wbytes_q + CNT_W'(taken);
    assign push_last  = fin;
    assign total      = total_q;
    assign early      = early_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0; total_q <= '0; idx_q <= '0; wbuf_q <= '0;
            wbytes_q <= '0; done_q <= 1'b0; early_q <= 1'b0;
        end else if (clear || load) begin
            rem_q    <= clear ? '0 : load_len;
            total_q  <= '0;
            idx_q    <= '0;
            wbuf_q   <= '0;
            wbytes_q <= '0;
            done_q   <= 1'b0;
            early_q  <= 1'b0;
        end else if (accept) begin
            rem_q   <= rem_q - taken;
            total_q <= total_q + taken;
            if (push) begin
                idx_q    <= '0;
                wbuf_q   <= '0;
                wbytes_q <= '0;
            end else begin
                idx_q    <= idx_q + 1'b1;
                wbuf_q   <= push_word;
                wbytes_q <= push_bytes;
            end
            if (fin) begin
                done_q  <= 1'b1;
                early_q <= rem_q > taken;
            end
        end
    end
endmodule

// File: rtl/d2h_stream_agent.sv
module d2h_stream_agent
    import d2h_agent_pkg::*;
#(
    parameter int IN_W         = 32,
    parameter int DATA_W       = 64,
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 16,
    parameter int FIFO_DEPTH   = 4,
    parameter bit UNALIGNED_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IN_W-1:0]     s_tdata,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic                s_tlast,
    input  logic                desc_valid,
    output logic                desc_ready,
    input  logic [ADDR_W-1:0]   desc_addr,
    input  logic [LEN_W-1:0]    desc_len,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic                m_tlast,
    output logic                cpl_valid,
    output logic [LEN_W-1:0]    cpl_bytes,
    output logic                cpl_early,
    input  logic                srst_req,
    output logic                srst_done
);
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int CNT_W      = $clog2(DATA_BYTES + 1);
    localparam int ENTRY_W    = DATA_W + CNT_W + 1;

    agent_state_e state, state_nx;

    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   len_q;
    logic               done_q;
    logic               load, in_en, pk_ready, clear;
    logic               pk_push, pk_last;
    logic [DATA_W-1:0]  pk_word;
    logic [CNT_W-1:0]   pk_bytes;
    logic               fifo_pop, fifo_full, fifo_empty;
    logic [ENTRY_W-1:0] fifo_rdata;
    logic [DATA_W-1:0]  head_data;
    logic [CNT_W-1:0]   head_cnt;
    logic               head_last;
    logic [DATA_W-1:0]  hdr_word;
    logic [ADDR_W-1:0]  addr_in;

    assign {head_last, head_cnt, head_data} = fifo_rdata;

    d2h_pack #(
        .IN_W(IN_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load(load),
        .load_len(desc_len), .in_en(in_en), .fifo_full(fifo_full),
        .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .ready(pk_ready), .push(pk_push), .push_word(pk_word),
        .push_bytes(pk_bytes), .push_last(pk_last),
        .total(cpl_bytes), .early(cpl_early)
    );

    d2h_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push(pk_push),
        .wdata({pk_last, pk_bytes, pk_word}), .pop(fifo_pop),
        .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
    );

    generate
        if (UNALIGNED_EN) begin : g_byte_addr
            assign addr_in = desc_addr;
        end else begin : g_word_addr
            assign addr_in = desc_addr & ~ADDR_W'(DATA_BYTES - 1);
        end
    endgenerate

    always_comb begin
        hdr_word = '0;
        hdr_word[ADDR_W-1:0] = addr_q;
        hdr_word[ADDR_W +: LEN_W] = len_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (srst_req) state_nx = ST_DRAIN;
                      else if (desc_valid) state_nx = ST_HDR;
            ST_HDR:   if (srst_req) state_nx = ST_DRAIN;
                      else if (m_tready) state_nx = ST_PAY;
            ST_PAY:   if (srst_req) state_nx = ST_DRAIN;
                      else if (m_tready && !fifo_empty && head_last) state_nx = ST_CPL;
            ST_CPL:   state_nx = srst_req ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: if (!s_tvalid && fifo_empty) state_nx = ST_CLEAR;
            ST_CLEAR: state_nx = srst_req ? ST_DRAIN : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        desc_ready = 1'b0;
        in_en      = 1'b0;
        m_tvalid   = 1'b0;
        m_tdata    = '0;
        m_tkeep    = '0;
        m_tlast    = 1'b0;
        fifo_pop   = 1'b0;
        cpl_valid  = 1'b0;
        clear      = 1'b0;
        s_tready   = pk_ready;
        unique case (state)
            ST_IDLE:  desc_ready = !srst_req;
            ST_HDR: begin
                in_en    = 1'b1;
                m_tvalid = 1'b1;
                m_tdata  = hdr_word;
                m_tkeep  = '1;
            end
            ST_PAY: begin
                in_en    = 1'b1;
                m_tvalid = !fifo_empty;
                m_tdata  = head_data;
                m_tlast  = head_last;
                for (int b = 0; b < DATA_BYTES; b++) m_tkeep[b] = CNT_W'(b) < head_cnt;
                fifo_pop = m_tready && !fifo_empty;
            end
            ST_CPL:   cpl_valid = 1'b1;
            ST_DRAIN: begin
                s_tready = 1'b1;
                fifo_pop = !fifo_empty;
            end
            ST_CLEAR: clear = 1'b1;
            default:  ;
        endcase
    end

    assign load      = desc_ready && desc_valid;
    assign srst_done = done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (load) begin
                addr_q <= addr_in;
                len_q  <= desc_len;
            end
            if (clear) begin
                addr_q <= '0;
                len_q  <= '0;
                done_q <= 1'b1;
            end
            if (srst_req) done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/d2h_stream_agent_chk.sv
module d2h_stream_agent_chk
    import d2h_agent_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input agent_state_e        state,
    input logic                s_tready,
    input logic                desc_ready,
    input logic                m_tvalid,
    input logic                m_tready,
    input logic                m_tlast,
    input logic [DATA_W-1:0]   m_tdata,
    input logic [DATA_W/8-1:0] m_tkeep,
    input logic                cpl_valid,
    input logic [LEN_W-1:0]    cpl_bytes,
    input logic                cpl_early,
    input logic [LEN_W-1:0]    len_q,
    input logic                srst_req,
    input logic                srst_done
);
    a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !srst_req) |=>
        (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));

    a_r4_keep_contig: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ((m_tkeep != '0) && ((m_tkeep & (m_tkeep + 1'b1)) == '0)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);

    a_r7_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(m_tvalid && m_tready && m_tlast));

    a_r7_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_early) |-> (cpl_bytes == len_q));

    a_r6_short_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_early) |-> (cpl_bytes < len_q));

    a_r8_no_desc_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> !desc_ready);

    a_r10_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (s_tready && !m_tvalid && !cpl_valid));

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> !srst_done);
endmodule

bind d2h_stream_agent d2h_stream_agent_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .s_tready(s_tready),
    .desc_ready(desc_ready), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .cpl_valid(cpl_valid), .cpl_bytes(cpl_bytes), .cpl_early(cpl_early),
    .len_q(len_q), .srst_req(srst_req), .srst_done(srst_done)
);

// File: tb/test_d2h_stream_agent.sv
module test_d2h_stream_agent;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W = 32, DATA_W = 64, ADDR_W = 32, LEN_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [IN_W-1:0] s_tdata = '0;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic desc_valid = 1'b0, desc_ready;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic [DATA_W-1:0] m_tdata;
    logic [7:0] m_tkeep;
    logic m_tvalid, m_tlast, m_tready = 1'b1;
    logic cpl_valid, cpl_early, srst_req = 1'b0, srst_done;
    logic [LEN_W-1:0] cpl_bytes;

    int n_checks = 0, n_err = 0, cyc = 0, mt_mode = 0;
    bit in_srst = 1'b0;
    logic [73:0] exp_beats[$];   // {is_hdr, last, keep, data}
    logic [16:0] exp_cpl[$];     // {bytes, early}
    logic prev_stall = 1'b0;
    logic [72:0] prev_beat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    d2h_stream_agent #(.IN_W(IN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                       .LEN_W(LEN_W), .FIFO_DEPTH(4), .UNALIGNED_EN(1'b1)) i_d2h_stream_agent (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .desc_valid(desc_valid),
        .desc_ready(desc_ready), .desc_addr(desc_addr), .desc_len(desc_len),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .cpl_valid(cpl_valid),
        .cpl_bytes(cpl_bytes), .cpl_early(cpl_early), .srst_req(srst_req),
        .srst_done(srst_done));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] beat(input int seed, input int i);
        return {8'(seed), 8'(i), 16'hC35A ^ 16'(i * 7)};
    endfunction

    // Arbiter-side ready pattern
    always @(posedge clk) begin
        #2;
        cyc++;
        case (mt_mode)
            0: m_tready = 1'b1;
            1: m_tready = cyc[0] ^ cyc[2];
            default: m_tready = 1'b0;
        endcase
    end

    // Scoreboard model: expected beats and completion from the descriptor
    task automatic expect_desc(input int addr, input int len, input int nb, input int seed);
        int total, nwords;
        logic [63:0] hdr, w;
        logic [7:0] keep;
        total  = (nb * 4 < len) ? nb * 4 : len;
        nwords = (nb + 1) / 2;
        hdr = '0;
        hdr[31:0]  = 32'(addr);
        hdr[47:32] = 16'(len);
        exp_beats.push_back({1'b1, 1'b0, 8'hFF, hdr});
        for (int k = 0; k < nwords; k++) begin
            int cnt;
            cnt = total - 8 * k;
            if (cnt > 8) cnt = 8;
            w = '0;
            w[31:0] = beat(seed, 2 * k);
            if (2 * k + 1 < nb) w[63:32] = beat(seed, 2 * k + 1);
            keep = '0;
            for (int b = 0; b < 8; b++) if (b < cnt) keep[b] = 1'b1;
            for (int b = 0; b < 8; b++) if (!keep[b]) w[b*8 +: 8] = 8'h00;
            exp_beats.push_back({1'b0, k == nwords - 1, keep, w});
        end
        exp_cpl.push_back({16'(total), nb * 4 < len});
    endtask

    task automatic drive_desc(input int addr, input int len);
        int guard = 0;
        tick();
        desc_valid = 1'b1;
        desc_addr  = 32'(addr);
        desc_len   = 16'(len);
        #1;
        while (!desc_ready && guard < 500) begin tick(); #1; guard++; end
        if (guard >= 500) chk(1'b0, "R7 descriptor not taken", 0, 1);
        tick();
        desc_valid = 1'b0;
    endtask

    task automatic send_beats(input int seed, input int from, input int to, input int nb, input bit tl);
        for (int i = from; i <= to; i++) begin
            int guard = 0;
            tick();
            s_tvalid = 1'b1;
            s_tdata  = beat(seed, i);
            s_tlast  = tl && (i == nb - 1);
            #1;
            while (!s_tready && guard < 500) begin tick(); #1; guard++; end
            if (guard >= 500) chk(1'b0, "R8 sink stuck", 0, 1);
        end
        tick();
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((exp_beats.size() != 0 || exp_cpl.size() != 0 || !desc_ready) && guard < 500) begin
            tick(); guard++;
        end
        chk(guard < 500, "R7 packet or completion missing", 64'(exp_beats.size() + exp_cpl.size()), 0);
    endtask

    task automatic run(input int addr, input int len, input int nb, input bit tl, input int seed);
        expect_desc(addr, len, nb, seed);
        drive_desc(addr, len);
        send_beats(seed, 0, nb - 1, nb, tl);
        wait_idle();
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !in_srst)
                chk(m_tvalid && {m_tlast, m_tkeep, m_tdata} == prev_beat, "R9 stalled beat changed",
                    m_tdata, prev_beat[63:0]);
            prev_stall = m_tvalid && !m_tready;
            prev_beat  = {m_tlast, m_tkeep, m_tdata};
            if (m_tvalid && m_tready) begin
                if (exp_beats.size() == 0) begin
                    chk(1'b0, "R2 unexpected beat", m_tdata, 0);
                end else begin
                    logic [73:0] e;
                    logic [63:0] mask;
                    e = exp_beats.pop_front();
                    for (int b = 0; b < 8; b++) mask[b*8 +: 8] = {8{m_tkeep[b]}};
                    if (e[73]) begin
                        chk(m_tdata == e[63:0], "R2 header data", m_tdata, e[63:0]);
                        chk(m_tkeep == e[71:64] && !m_tlast, "R2 header keep/last",
                            {m_tlast, m_tkeep}, {1'b0, e[71:64]});
                    end else begin
                        chk((m_tdata & mask) == e[63:0], "R3 payload lanes", m_tdata & mask, e[63:0]);
                        chk(m_tkeep == e[71:64] && m_tlast == e[72], "R4 keep/last",
                            {m_tlast, m_tkeep}, e[72:64]);
                    end
                end
            end
            if (cpl_valid) begin
                if (exp_cpl.size() == 0) begin
                    chk(1'b0, "R10 unexpected completion", {cpl_bytes, cpl_early}, 0);
                end else begin
                    logic [16:0] c;
                    c = exp_cpl.pop_front();
                    chk({cpl_bytes, cpl_early} == c, c[0] ? "R6 early completion" : "R7 completion",
                        {cpl_bytes, cpl_early}, c);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk(!s_tready && !m_tvalid && !cpl_valid && !srst_done && desc_ready, "R1 reset state",
            {s_tready, m_tvalid, cpl_valid, srst_done, desc_ready}, 5'b00001);

        // R8: no descriptor active
        tick(); s_tvalid = 1'b1; #1;
        chk(!s_tready, "R8 ready without descriptor", s_tready, 0);
        s_tvalid = 1'b0;

        run(32'h1000, 16, 4, 1'b1, 1);   // R3 R7 full length, tlast at end
        run(32'h2003, 10, 3, 1'b0, 2);   // R5 cut mid-beat, odd address
        tick(); s_tvalid = 1'b1; #1;
        chk(!s_tready, "R5 beat after length used", s_tready, 0);
        s_tvalid = 1'b0;
        run(32'h4000, 40, 3, 1'b1, 3);   // R6 early tlast
        run(32'h3001, 1, 1, 1'b0, 4);    // R5 single byte

        mt_mode = 1;                     // R9 backpressure pattern
        run(32'h5005, 37, 10, 1'b0, 5);
        mt_mode = 0;

        // R8: FIFO full stalls the sink
        mt_mode = 2;
        expect_desc(32'h6000, 64, 16, 6);
        drive_desc(32'h6000, 64);
        send_beats(6, 0, 7, 16, 1'b0);
        tick(); s_tvalid = 1'b1; s_tdata = beat(6, 8); #1;
        chk(!s_tready, "R8 ready with full FIFO", s_tready, 0);
        chk(m_tvalid && m_tdata[47:32] == 16'd64, "R2 header held under stall", m_tdata, 64);
        s_tvalid = 1'b0;
        mt_mode = 0;
        send_beats(6, 8, 15, 16, 1'b0);
        wait_idle();

        // R10: soft reset in the middle of a descriptor
        mt_mode = 2;
        in_srst = 1'b1;
        drive_desc(32'h7000, 40);
        send_beats(9, 0, 2, 10, 1'b0);
        tick(); srst_req = 1'b1; s_tvalid = 1'b1; s_tdata = beat(9, 3);
        tick(); srst_req = 1'b0; #1;
        chk(s_tready && !m_tvalid, "R10 drain accepts input, output quiet",
            {s_tready, m_tvalid}, 2'b10);
        chk(!srst_done, "R10 done low while draining", srst_done, 0);
        tick(); s_tvalid = 1'b0;
        begin
            int guard = 0;
            while (!srst_done && guard < 20) begin tick(); guard++; end
        end
        chk(srst_done && desc_ready, "R10 done after drain", {srst_done, desc_ready}, 2'b11);
        in_srst = 1'b0;
        mt_mode = 0;
        run(32'h8002, 20, 5, 1'b1, 11);  // R10 no stale words afterwards

        repeat (3) tick();
        chk(exp_beats.size() == 0 && exp_cpl.size() == 0, "R7 scoreboard empty",
            64'(exp_beats.size() + exp_cpl.size()), 0);
        summary();
        $finish;
    end
endmodule